// File: doc/BRIEF.md
# GPIO Group Interrupt Combiner

This block merges many general-purpose input pins into a single interrupt for each of several pin groups. Each group has its own enable mask and its own polarity mask. The pins that are enabled in a group are first adjusted for polarity, so that an active pin always reads as 1. They are then reduced to one bit, either by OR ("any enabled pin is active") or by AND ("every enabled pin is active"). The group's mode control picks the reduction.

The pins first pass through a two-stage synchronizer. The reduced result is then registered, so the delay from a pin to the interrupt is fixed. The group interrupt can follow that result directly (level trigger). It can instead come from a sticky status bit (edge trigger), which is set when the reduced result rises and is cleared by a one-cycle clear pulse. Each group also has a wake-up enable, which gates its interrupt onto a wake-up request output.

Top module: `pin_group_combiner`

## Requirements
- R1: A group's polarity bit of 0 makes its pin active when high. A polarity bit of 1 makes the pin active when low: the synchronized pin value is XORed with the polarity bit.
- R2: A pin whose enable bit is 0 in a group has no effect on that group's result, whatever its level or polarity, in both OR and AND mode.
- R3: In OR mode (`grp_and_mode` bit = 0), the group result is 1 when at least one enabled pin is active.
- R4: In AND mode (`grp_and_mode` bit = 1), the group result is 1 when every enabled pin is active, and 0 when any enabled pin is inactive.
- R5: In AND mode with no pin enabled, the group result is 0.
- R6: Each group uses only its own enable, polarity, mode, wake and clear inputs. A configuration applied to one group does not change another group's outputs.
- R7: In level mode (`grp_edge_mode` bit = 0), `grp_irq` equals the group result. A pin change driven between two clock edges shows on `grp_irq` after the third rising edge that follows it, and not after the second.
- R8: In edge mode (`grp_edge_mode` bit = 1), a 0-to-1 change of the group result sets `grp_irq`, and `grp_irq` stays 1 after the result falls back to 0.
- R9: In edge mode, a one-cycle `grp_clear` pulse clears `grp_irq`. It is not set again until the group result makes a new 0-to-1 change. In level mode, `grp_clear` has no effect on `grp_irq`.
- R10: `grp_wake` of a group equals that group's `grp_irq` ANDed with its `grp_wake_en` bit.
- R11: While `rst` is high, and in the cycle after it falls, `grp_irq` and `grp_wake` are 0 for every group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NUM_PINS | Asynchronous GPIO pin levels |
| grp_enable | input | NUM_GROUPS x NUM_PINS | Per-group pin enable mask |
| grp_invert | input | NUM_GROUPS x NUM_PINS | Per-group polarity mask (1 = active low) |
| grp_and_mode | input | NUM_GROUPS | Reduction select per group (0 = OR, 1 = AND) |
| grp_edge_mode | input | NUM_GROUPS | Trigger select per group (0 = level, 1 = edge) |
| grp_wake_en | input | NUM_GROUPS | Wake-up enable per group |
| grp_clear | input | NUM_GROUPS | Write-1 pulse that clears a group's sticky status |
| grp_irq | output | NUM_GROUPS | Group interrupt |
| grp_wake | output | NUM_GROUPS | Group wake-up request |

## Verification
The assertions check four things on every cycle. In level mode the interrupt tracks the previous cycle's reduced value. In edge mode a rising result sets the sticky bit, and the bit holds until a clear. AND mode with an empty mask never reports active, and a wake request never appears without its interrupt. Only the bench's scenarios can show the rest: the polarity and mask arithmetic across chosen pin patterns, the exact three-edge latency from a pin, that the groups are independent, and that a clear is ignored in level mode.

// File: rtl/grp_pkg.sv
package grp_pkg;

    typedef enum logic {
        COMB_OR  = 1'b0,
        COMB_AND = 1'b1
    } combine_e;

    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_EDGE  = 1'b1
    } trigger_e;

    typedef struct packed {
        combine_e combine;
        trigger_e trigger;
        logic     wake_en;
    } grp_mode_t;

    function automatic grp_mode_t make_mode(logic and_bit, logic edge_bit, logic wake_bit);
        grp_mode_t m;
        m.combine = and_bit ? COMB_AND : COMB_OR;
        m.trigger = edge_bit ? TRIG_EDGE : TRIG_LEVEL;
        m.wake_en = wake_bit;
        return m;
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= '0;
                    else     stage_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/group_reduce.sv
module group_reduce
    import grp_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pins,
    input  logic [NUM_PINS-1:0] enable,
    input  logic [NUM_PINS-1:0] invert,
    input  combine_e            combine,
    output logic                result
);
    logic [NUM_PINS-1:0] active;
    logic                any_hit;
    logic                all_hit;
    logic                has_enabled;

    always_comb begin
        active      = pins ^ invert;
        any_hit     = |(active & enable);
        all_hit     = &(active | ~enable);
        has_enabled = |enable;
        case (combine)
            COMB_AND: result = all_hit & has_enabled;
            default:  result = any_hit;
        endcase
    end

    // R5: an empty mask in AND mode never reports active
    assert_and_empty_R5: assert property (@(posedge clk) disable iff (rst)
        (combine == COMB_AND && enable == '0) |-> !result);
    // R3: OR mode can only report active if some enabled pin differs from its polarity
    assert_or_needs_pin_R3: assert property (@(posedge clk) disable iff (rst)
        (combine == COMB_OR && result) |-> (((pins ^ invert) & enable) != '0));
endmodule

// File: rtl/group_trigger.sv
module group_trigger
    import grp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     comb_raw,
    input  trigger_e trigger,
    input  logic     clear,
    output logic     irq
);
    logic comb_q;
    logic sticky_q;
    logic rise;

    assign rise = (trigger == TRIG_EDGE) && comb_raw && !comb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            comb_q   <= 1'b0;
            sticky_q <= 1'b0;
        end else begin
            comb_q <= comb_raw;
            if (rise)       sticky_q <= 1'b1;
            else if (clear) sticky_q <= 1'b0;
        end
    end

    assign irq = (trigger == TRIG_EDGE) ? sticky_q : comb_q;

    // R7: level mode presents last cycle's reduced value
    assert_level_follows_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (trigger == TRIG_EDGE || irq == $past(comb_raw)));
    // R8: a rising reduced value in edge mode raises the interrupt
    assert_edge_sets_R8: assert property (@(posedge clk) disable iff (rst)
        rise |=> (irq || trigger != TRIG_EDGE));
    // R9: sticky status holds until a clear arrives
    assert_sticky_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (trigger == TRIG_EDGE && irq && !clear) |=> (irq || trigger != TRIG_EDGE));
endmodule

// File: rtl/pin_group_combiner.sv
module pin_group_combiner
    import grp_pkg::*;
#(
    parameter int NUM_PINS    = 32,
    parameter int NUM_GROUPS  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [NUM_PINS-1:0]                 pin_in,
    input  logic [NUM_GROUPS-1:0][NUM_PINS-1:0] grp_enable,
    input  logic [NUM_GROUPS-1:0][NUM_PINS-1:0] grp_invert,
    input  logic [NUM_GROUPS-1:0]               grp_and_mode,
    input  logic [NUM_GROUPS-1:0]               grp_edge_mode,
    input  logic [NUM_GROUPS-1:0]               grp_wake_en,
    input  logic [NUM_GROUPS-1:0]               grp_clear,
    output logic [NUM_GROUPS-1:0]               grp_irq,
    output logic [NUM_GROUPS-1:0]               grp_wake
);
    logic [NUM_PINS-1:0]   pins_s;
    grp_mode_t             mode [NUM_GROUPS];
    logic [NUM_GROUPS-1:0] comb_raw;

    pin_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pin_in),
        .sync_out (pins_s)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_GROUPS; g++) begin : g_group
            assign mode[g] = make_mode(grp_and_mode[g], grp_edge_mode[g], grp_wake_en[g]);

            group_reduce #(
                .NUM_PINS (NUM_PINS)
            ) u_reduce (
                .clk     (clk),
                .rst     (rst),
                .pins    (pins_s),
                .enable  (grp_enable[g]),
                .invert  (grp_invert[g]),
                .combine (mode[g].combine),
                .result  (comb_raw[g])
            );

            group_trigger u_trig (
                .clk      (clk),
                .rst      (rst),
                .comb_raw (comb_raw[g]),
                .trigger  (mode[g].trigger),
                .clear    (grp_clear[g]),
                .irq      (grp_irq[g])
            );

            assign grp_wake[g] = grp_irq[g] & mode[g].wake_en;

            // R10: no wake request without its interrupt
            assert_wake_needs_irq_R10: assert property (@(posedge clk) disable iff (rst)
                grp_wake[g] |-> grp_irq[g]);
        end
    endgenerate
endmodule

// File: tb/pin_group_combiner_tb.sv
`timescale 1ns/1ps
module pin_group_combiner_tb;
    localparam int NP = 32;
    localparam int NG = 2;
    localparam int NV = 9;

    logic                clk = 1'b0;
    logic                rst;
    logic [NP-1:0]       pin_in;
    logic [NG-1:0][NP-1:0] grp_enable, grp_invert;
    logic [NG-1:0]       grp_and_mode, grp_edge_mode, grp_wake_en, grp_clear;
    logic [NG-1:0]       grp_irq, grp_wake;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    pin_group_combiner #(.NUM_PINS(NP), .NUM_GROUPS(NG), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .pin_in(pin_in),
        .grp_enable(grp_enable), .grp_invert(grp_invert),
        .grp_and_mode(grp_and_mode), .grp_edge_mode(grp_edge_mode),
        .grp_wake_en(grp_wake_en), .grp_clear(grp_clear),
        .grp_irq(grp_irq), .grp_wake(grp_wake)
    );

    // group 0 vectors: pins, enable, invert, and-mode, expected result
    localparam logic [NP-1:0] V_PINS [NV] = '{32'h0000_00F0, 32'h0000_00F0, 32'h0000_0000,
        32'hFFFF_FFFF, 32'h0000_000F, 32'h0000_0007, 32'h0000_0007, 32'h8000_0000, 32'h0000_0000};
    localparam logic [NP-1:0] V_EN   [NV] = '{32'h0000_0010, 32'h0000_0001, 32'h0000_0001,
        32'h0000_0000, 32'h0000_000F, 32'h0000_000F, 32'h0000_000F, 32'h8000_0001, 32'h0000_0000};
    localparam logic [NP-1:0] V_INV  [NV] = '{32'h0, 32'h0, 32'h0000_0001,
        32'h0, 32'h0, 32'h0, 32'h0000_0008, 32'h0, 32'hFFFF_FFFF};
    localparam logic V_AND [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
    localparam logic V_EXP [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
    localparam string V_TAG [NV] = '{"R3", "R2", "R1", "R5", "R4", "R4", "R1", "R3", "R2"};

    task automatic check(input string tag, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        pin_in = '1;
        grp_enable = '1; grp_invert = '0;
        grp_and_mode = '0; grp_edge_mode = '0; grp_wake_en = '1; grp_clear = '0;
        ticks(3);
        // R11: reset state
        check("R11 irq0 in reset", grp_irq[0], 1'b0);
        check("R11 wake1 in reset", grp_wake[1], 1'b0);
        rst = 1'b0;
        ticks(1);
        check("R11 irq0 after reset", grp_irq[0], 1'b0);

        // table: group 0 varies, group 1 fixed OR over all pins (R6, R10)
        for (int i = 0; i < NV; i++) begin
            pin_in          = V_PINS[i];
            grp_enable[0]   = V_EN[i];
            grp_invert[0]   = V_INV[i];
            grp_and_mode[0] = V_AND[i];
            grp_enable[1]   = '1;
            grp_invert[1]   = '0;
            grp_and_mode[1] = 1'b0;
            grp_wake_en     = 2'b10;
            ticks(4);
            check(V_TAG[i], grp_irq[0], V_EXP[i]);
            check("R6 group1 independent", grp_irq[1], |V_PINS[i]);
            check("R10 wake1", grp_wake[1], |V_PINS[i]);
            check("R10 wake0 disabled", grp_wake[0], 1'b0);
        end

        // R7: latency of three edges in level mode
        pin_in = '0; grp_enable[0] = 32'h1; grp_invert[0] = '0; grp_and_mode[0] = 1'b0;
        ticks(4);
        check("R7 idle", grp_irq[0], 1'b0);
        pin_in = 32'h1;
        ticks(2);
        check("R7 not after two edges", grp_irq[0], 1'b0);
        ticks(1);
        check("R7 after three edges", grp_irq[0], 1'b1);
        // R9: clear ignored in level mode
        grp_clear[0] = 1'b1; ticks(1); grp_clear[0] = 1'b0; ticks(1);
        check("R9 clear ignored in level", grp_irq[0], 1'b1);

        // R8: edge mode sticky
        pin_in = '0; ticks(4);
        grp_clear[0] = 1'b1; grp_edge_mode[0] = 1'b1; ticks(1); grp_clear[0] = 1'b0;
        ticks(1);
        check("R8 edge idle", grp_irq[0], 1'b0);
        pin_in = 32'h1; ticks(4);
        check("R8 set on rise", grp_irq[0], 1'b1);
        pin_in = '0; ticks(4);
        check("R8 held after fall", grp_irq[0], 1'b1);
        grp_wake_en[0] = 1'b1; ticks(1);
        check("R10 wake0 enabled", grp_wake[0], 1'b1);
        grp_clear[0] = 1'b1; ticks(1); grp_clear[0] = 1'b0;
        check("R9 cleared", grp_irq[0], 1'b0);
        pin_in = 32'h1; ticks(4);
        check("R8 second rise", grp_irq[0], 1'b1);
        grp_clear[0] = 1'b1; ticks(1); grp_clear[0] = 1'b0; ticks(3);
        check("R9 no reset while high", grp_irq[0], 1'b0);
        check("R6 group1 level unaffected", grp_irq[1], 1'b1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule